// File: doc/BRIEF.md
# Four-Port Shared Arithmetic and Shift Engine

This block serves four independent requesters that share one adder/subtractor and one shifter. Each requester owns a 4-bit command input, a 32-bit data input, a 2-bit response output and a 32-bit result output. A request takes two cycles to deliver. The first operand comes with the command, and the second operand follows on the data lines in the next cycle. Command lines are not examined in that second cycle.

Once both operands are held, a valid request joins a first-come first-served line for its execution unit. There is one line for add/subtract and one for shifts, and the two units work in parallel. Each unit completes one request per cycle. The outcome appears on the requester's own response and result lines for one cycle. Each port may have only one request in flight. A command issued on a port while that port's earlier request is still waiting is reported back as a protocol error.

Top module: `qcalc_top`

## Requirements
- R1: While reset is high, every response output is 0 and every result output is 0 in the cycle after each reset edge. Reset discards all captured and queued requests.
- R2: Command code 1 adds operand1 (data in the command cycle) to operand2 (data in the next cycle). On an idle unit the response code 1 and the 32-bit sum appear two cycles after the operand2 cycle.
- R3: Command code 2 computes operand1 minus operand2 as unsigned values. If operand1 is less than operand2 (borrow), the response is code 2 with result 0. Otherwise it is code 1 with the difference.
- R4: An addition whose unsigned sum exceeds 32 bits returns response code 2 with result 0.
- R5: Command code 5 shifts operand1 left by operand2 places, and code 6 shifts it right. Vacated bits are filled with zeros, and the response is code 1.
- R6: A shift whose amount (operand2, read as unsigned) is greater than 31 returns response code 2 with result 0.
- R7: Command codes 3, 4 and 7 to 15 are invalid. They return response code 2 with result 0 in the cycle after the operand2 cycle, and they never occupy a unit.
- R8: Command code 0 is a no-op. Data presented with it has no effect, and no response follows.
- R9: Each unit completes at most one request per cycle, in order of arrival. Requests for the same unit that become ready in the same cycle are served lowest port number first. An add/subtract and a shift for different ports may complete in the same cycle.
- R10: A non-zero command on a port whose request is waiting for a unit returns response code 3 with result 0 in the next cycle. The waiting request is kept, and it completes in a later cycle than that error response.
- R11: A response of code 1 or 2 is driven for exactly one cycle. Response and result are 0 in every cycle that carries no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 4 per port (16) | Command code of each port, port 0 in the low bits |
| data_i | input | 32 per port (128) | Operand1 in the command cycle, operand2 in the cycle after |
| resp_o | output | 2 per port (8) | 0 none, 1 done, 2 invalid or overflow/underflow, 3 protocol error |
| result_o | output | 32 per port (128) | Result, valid in the cycle its response is non-zero |

## Verification
The case that stresses the design is a protocol error on a port that collides with that same port reaching the head of its unit's line. Both outcomes want the same response lines in the same cycle. The bench sets this up by launching four additions in one cycle and then pushing commands onto a port that is still queued. It judges the result against a behavioural model: the error code must appear first, and the pending sum must follow in a later cycle without being lost. The concurrent completion of an add and a shift on different ports is provoked in the same way, and a long stretch of mixed random traffic, protocol violations included, is compared cycle by cycle.

// File: rtl/qcalc_pkg.sv
package qcalc_pkg;

   localparam int CMD_W = 4;
   localparam int RSP_W = 2;

   localparam logic [CMD_W-1:0] CMD_NOP = 4'd0;
   localparam logic [CMD_W-1:0] CMD_ADD = 4'd1;
   localparam logic [CMD_W-1:0] CMD_SUB = 4'd2;
   localparam logic [CMD_W-1:0] CMD_SHL = 4'd5;
   localparam logic [CMD_W-1:0] CMD_SHR = 4'd6;

   localparam logic [RSP_W-1:0] RSP_NONE = 2'd0;
   localparam logic [RSP_W-1:0] RSP_OK   = 2'd1;
   localparam logic [RSP_W-1:0] RSP_BAD  = 2'd2;
   localparam logic [RSP_W-1:0] RSP_INT  = 2'd3;

   typedef enum logic [1:0] {PS_IDLE, PS_OPND2, PS_WAIT} port_st_e;
   typedef enum logic [1:0] {K_ADD, K_SUB, K_SHL, K_SHR} op_kind_e;

   function automatic logic cmd_known(input logic [CMD_W-1:0] c);
      return (c == CMD_ADD) || (c == CMD_SUB) || (c == CMD_SHL) || (c == CMD_SHR);
   endfunction

   function automatic op_kind_e cmd_kind(input logic [CMD_W-1:0] c);
      case (c)
         CMD_SUB: return K_SUB;
         CMD_SHL: return K_SHL;
         CMD_SHR: return K_SHR;
         default: return K_ADD;
      endcase
   endfunction

endpackage

// File: rtl/qcalc_port.sv
module qcalc_port
   import qcalc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [W-1:0]     data_i,
   input  logic             done_i,
   output logic [W-1:0]     op1_o,
   output logic [W-1:0]     op2_o,
   output op_kind_e         kind_o,
   output logic             wait_o,
   output logic             err_o,
   output logic             inv_o,
   output logic             push_as_o,
   output logic             push_sh_o
);

   port_st_e   st_q;
   op_kind_e   kind_q;
   logic       ok_q;
   logic [W-1:0] op1_q, op2_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= PS_IDLE;
         kind_q <= K_ADD;
         ok_q   <= 1'b0;
         op1_q  <= '0;
         op2_q  <= '0;
      end else begin
         case (st_q)
            PS_IDLE: begin
               if (cmd_i != CMD_NOP) begin
                  kind_q <= cmd_kind(cmd_i);
                  ok_q   <= cmd_known(cmd_i);
                  op1_q  <= data_i;
                  st_q   <= PS_OPND2;
               end
            end
            PS_OPND2: begin
               op2_q <= data_i;
               st_q  <= ok_q ? PS_WAIT : PS_IDLE;
            end
            PS_WAIT: begin
               if (done_i) st_q <= PS_IDLE;
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   logic is_arith;
   assign is_arith  = (kind_q == K_ADD) || (kind_q == K_SUB);

   assign op1_o     = op1_q;
   assign op2_o     = op2_q;
   assign kind_o    = kind_q;
   assign wait_o    = (st_q == PS_WAIT);
   assign err_o     = (st_q == PS_WAIT) && (cmd_i != CMD_NOP);
   assign inv_o     = (st_q == PS_OPND2) && !ok_q;
   assign push_as_o = (st_q == PS_OPND2) && ok_q && is_arith;
   assign push_sh_o = (st_q == PS_OPND2) && ok_q && !is_arith;

endmodule

// File: rtl/qcalc_fcfs.sv
module qcalc_fcfs #(
   parameter int N = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  push_i,
   input  logic          pop_i,
   output logic          head_vld_o,
   output logic [((N > 1) ? $clog2(N) : 1)-1:0] head_id_o
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam int CW = $clog2(N + 1);

   if (N < 1) begin : g_bad_n
      $error("qcalc_fcfs: N must be at least 1");
   end

   logic [IW-1:0] slot_q [N];
   logic [IW-1:0] slot_d [N];
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      int fill;
      slot_d = slot_q;
      if (pop_i) begin
         for (int i = 0; i < N - 1; i++) slot_d[i] = slot_q[i+1];
      end
      fill = int'(cnt_q) - (pop_i ? 1 : 0);
      for (int p = 0; p < N; p++) begin
         if (push_i[p]) begin
            if (fill < N) slot_d[fill] = IW'(p);
            fill = fill + 1;
         end
      end
      cnt_d = CW'(fill);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         for (int i = 0; i < N; i++) slot_q[i] <= '0;
      end else begin
         cnt_q  <= cnt_d;
         slot_q <= slot_d;
      end
   end

   assign head_vld_o = (cnt_q != '0);
   assign head_id_o  = slot_q[0];

endmodule

// File: rtl/qcalc_addsub.sv
module qcalc_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         bad_o
);

   logic [W:0] wide;

   always_comb begin
      if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
      else       wide = {1'b0, a_i} + {1'b0, b_i};
   end

   assign res_o = wide[W-1:0];
   assign bad_o = wide[W];

endmodule

// File: rtl/qcalc_shift.sv
module qcalc_shift #(
   parameter int W        = 32,
   parameter bit LOG_IMPL = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] amt_i,
   input  logic         left_i,
   output logic [W-1:0] res_o,
   output logic         bad_o
);

   localparam int SW = $clog2(W);

   if (W < 2) begin : g_bad_w
      $error("qcalc_shift: W must be at least 2");
   end

   assign bad_o = (amt_i > W'(W - 1));

   if (LOG_IMPL) begin : g_log
      logic [W-1:0] stg [SW+1];
      assign stg[0] = a_i;
      for (genvar s = 0; s < SW; s++) begin : g_stage
         assign stg[s+1] = amt_i[s] ? (left_i ? (stg[s] << (2**s)) : (stg[s] >> (2**s)))
                                    : stg[s];
      end
      assign res_o = stg[SW];
   end else begin : g_flat
      assign res_o = left_i ? (a_i << amt_i[SW-1:0]) : (a_i >> amt_i[SW-1:0]);
   end

endmodule

// File: rtl/qcalc_top.sv
module qcalc_top
   import qcalc_pkg::*;
#(
   parameter int NPORTS    = 4,
   parameter int W         = 32,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic [NPORTS-1:0][CMD_W-1:0]       cmd_i,
   input  logic [NPORTS-1:0][W-1:0]           data_i,
   output logic [NPORTS-1:0][RSP_W-1:0]       resp_o,
   output logic [NPORTS-1:0][W-1:0]           result_o
);

   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

   if (NPORTS < 1) begin : g_bad_np
      $error("qcalc_top: NPORTS must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("qcalc_top: W must be at least 2");
   end

   logic [NPORTS-1:0][W-1:0] op1_v, op2_v;
   op_kind_e                 kind_v [NPORTS];
   logic [NPORTS-1:0]        wait_vec, err_vec, inv_vec, push_as, push_sh;
   logic [NPORTS-1:0]        as_gnt, sh_gnt;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      qcalc_port #(.W(W)) u_port (
         .clk       (clk),
         .rst       (rst),
         .cmd_i     (cmd_i[p]),
         .data_i    (data_i[p]),
         .done_i    (as_gnt[p] | sh_gnt[p]),
         .op1_o     (op1_v[p]),
         .op2_o     (op2_v[p]),
         .kind_o    (kind_v[p]),
         .wait_o    (wait_vec[p]),
         .err_o     (err_vec[p]),
         .inv_o     (inv_vec[p]),
         .push_as_o (push_as[p]),
         .push_sh_o (push_sh[p])
      );
   end

   logic          as_vld, sh_vld, as_pop, sh_pop;
   logic [IW-1:0] as_id, sh_id;

   qcalc_fcfs #(.N(NPORTS)) u_q_as (
      .clk(clk), .rst(rst), .push_i(push_as), .pop_i(as_pop),
      .head_vld_o(as_vld), .head_id_o(as_id)
   );

   qcalc_fcfs #(.N(NPORTS)) u_q_sh (
      .clk(clk), .rst(rst), .push_i(push_sh), .pop_i(sh_pop),
      .head_vld_o(sh_vld), .head_id_o(sh_id)
   );

   // A port raising a protocol error this cycle owns its outputs; its
   // queued work waits one more cycle at the head of the line.
   assign as_pop = as_vld && !err_vec[as_id];
   assign sh_pop = sh_vld && !err_vec[sh_id];

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         as_gnt[p] = as_pop && (as_id == IW'(p));
         sh_gnt[p] = sh_pop && (sh_id == IW'(p));
      end
   end

   logic [W-1:0] as_res, sh_res;
   logic         as_bad, sh_bad;

   qcalc_addsub #(.W(W)) u_addsub (
      .a_i   (op1_v[as_id]),
      .b_i   (op2_v[as_id]),
      .sub_i (kind_v[as_id] == K_SUB),
      .res_o (as_res),
      .bad_o (as_bad)
   );

   qcalc_shift #(.W(W), .LOG_IMPL(LOG_SHIFT)) u_shift (
      .a_i    (op1_v[sh_id]),
      .amt_i  (op2_v[sh_id]),
      .left_i (kind_v[sh_id] == K_SHL),
      .res_o  (sh_res),
      .bad_o  (sh_bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_o   <= '0;
         result_o <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            if (err_vec[p]) begin
               resp_o[p]   <= RSP_INT;
               result_o[p] <= '0;
            end else if (inv_vec[p]) begin
               resp_o[p]   <= RSP_BAD;
               result_o[p] <= '0;
            end else if (as_gnt[p]) begin
               resp_o[p]   <= as_bad ? RSP_BAD : RSP_OK;
               result_o[p] <= as_bad ? '0 : as_res;
            end else if (sh_gnt[p]) begin
               resp_o[p]   <= sh_bad ? RSP_BAD : RSP_OK;
               result_o[p] <= sh_bad ? '0 : sh_res;
            end else begin
               resp_o[p]   <= RSP_NONE;
               result_o[p] <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/qcalc_chk.sv
module qcalc_chk
   import qcalc_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int W      = 32
) (
   input logic                         clk,
   input logic                         rst,
   input logic [NPORTS-1:0][CMD_W-1:0] cmd_i,
   input logic [NPORTS-1:0][RSP_W-1:0] resp_o,
   input logic [NPORTS-1:0][W-1:0]     result_o,
   input logic [NPORTS-1:0]            wait_vec,
   input logic [NPORTS-1:0]            as_gnt,
   input logic [NPORTS-1:0]            sh_gnt
);

   // R9: one completion per unit per cycle, only for a waiting port
   a_r9_one_addsub: assert property (@(posedge clk) disable iff (rst) $onehot0(as_gnt));
   a_r9_one_shift:  assert property (@(posedge clk) disable iff (rst) $onehot0(sh_gnt));

   for (genvar p = 0; p < NPORTS; p++) begin : g_p
      // R1: outputs cleared after a reset edge
      a_r1_reset_quiet: assert property (@(posedge clk)
         rst |=> (resp_o[p] == RSP_NONE) && (result_o[p] == '0));

      // R7: error-class responses carry a zero result
      a_r7_err_data_zero: assert property (@(posedge clk) disable iff (rst)
         ((resp_o[p] == RSP_BAD) || (resp_o[p] == RSP_INT)) |-> (result_o[p] == '0));

      // R9: a grant goes only to a port with a pending request
      a_r9_grant_pending: assert property (@(posedge clk) disable iff (rst)
         (as_gnt[p] || sh_gnt[p]) |-> wait_vec[p]);

      // R10: a command on a waiting port is answered with code 3
      a_r10_busy_cmd: assert property (@(posedge clk) disable iff (rst)
         (wait_vec[p] && (cmd_i[p] != CMD_NOP)) |=> (resp_o[p] == RSP_INT));

      // R11: completion responses last a single cycle
      a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
         ((resp_o[p] == RSP_OK) || (resp_o[p] == RSP_BAD)) |=> (resp_o[p] == RSP_NONE));
   end

endmodule

bind qcalc_top qcalc_chk #(.NPORTS(NPORTS), .W(W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_i    (cmd_i),
   .resp_o   (resp_o),
   .result_o (result_o),
   .wait_vec (wait_vec),
   .as_gnt   (as_gnt),
   .sh_gnt   (sh_gnt)
);

// File: tb/qcalc_top_test.sv
module qcalc_top_test;

   localparam int NP = 4;
   localparam int W  = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [NP-1:0][3:0]   cmd;
   logic [NP-1:0][W-1:0] data;
   logic [NP-1:0][1:0]   resp;
   logic [NP-1:0][W-1:0] result;

   qcalc_top #(.NPORTS(NP), .W(W)) uut (
      .clk(clk), .rst(rst), .cmd_i(cmd), .data_i(data),
      .resp_o(resp), .result_o(result)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   // behavioural reference
   int           mst [NP];      // 0 idle, 1 second operand, 2 waiting
   int           mcmd [NP];
   logic [W-1:0] ma [NP];
   logic [W-1:0] mb [NP];
   bit           mwaited [NP];
   int           aq [$];
   int           sq [$];
   logic [1:0]   exp_r [NP];
   logic [W-1:0] exp_d [NP];
   string        exp_t [NP];
   string        idle_tag = "R11";

   task automatic exec(input int p);
      longint unsigned a, b, s;
      a = longint'(ma[p]);
      b = longint'(mb[p]);
      exp_r[p] = 2'd1;
      case (mcmd[p])
         1: begin
            s = a + b;
            exp_t[p] = "R2";
            if (s > 64'hFFFF_FFFF) begin exp_r[p] = 2'd2; exp_d[p] = '0; exp_t[p] = "R4"; end
            else exp_d[p] = s[W-1:0];
         end
         2: begin
            exp_t[p] = "R3";
            if (a < b) begin exp_r[p] = 2'd2; exp_d[p] = '0; end
            else begin s = a - b; exp_d[p] = s[W-1:0]; end
         end
         default: begin
            exp_t[p] = "R5";
            if (b > 31) begin exp_r[p] = 2'd2; exp_d[p] = '0; exp_t[p] = "R6"; end
            else if (mcmd[p] == 5) begin s = (a << b) & 64'hFFFF_FFFF; exp_d[p] = s[W-1:0]; end
            else begin s = a >> b; exp_d[p] = s[W-1:0]; end
         end
      endcase
      if (mwaited[p]) exp_t[p] = "R9";
   endtask

   task automatic model_step();
      int  ost [NP];
      bit  err [NP];
      for (int p = 0; p < NP; p++) begin
         exp_r[p] = 2'd0;
         exp_d[p] = '0;
         exp_t[p] = rst ? "R1" : idle_tag;
      end
      if (rst) begin
         for (int p = 0; p < NP; p++) mst[p] = 0;
         aq.delete();
         sq.delete();
         return;
      end
      for (int p = 0; p < NP; p++) begin
         ost[p] = mst[p];
         err[p] = (mst[p] == 2) && (cmd[p] != 4'd0);
      end
      if (aq.size() > 0 && !err[aq[0]]) begin
         int h = aq.pop_front();
         exec(h);
         mst[h] = 0;
      end
      if (sq.size() > 0 && !err[sq[0]]) begin
         int h = sq.pop_front();
         exec(h);
         mst[h] = 0;
      end
      for (int p = 0; p < NP; p++) begin
         if (err[p]) begin
            exp_r[p] = 2'd3; exp_d[p] = '0; exp_t[p] = "R10";
         end else if (ost[p] == 0) begin
            if (cmd[p] != 4'd0) begin
               mcmd[p] = int'(cmd[p]); ma[p] = data[p]; mst[p] = 1;
            end
         end else if (ost[p] == 1) begin
            mb[p] = data[p];
            if (mcmd[p] == 1 || mcmd[p] == 2) begin
               aq.push_back(p); mwaited[p] = (aq.size() > 1); mst[p] = 2;
            end else if (mcmd[p] == 5 || mcmd[p] == 6) begin
               sq.push_back(p); mwaited[p] = (sq.size() > 1); mst[p] = 2;
            end else begin
               exp_r[p] = 2'd2; exp_d[p] = '0; exp_t[p] = "R7"; mst[p] = 0;
            end
         end
      end
   endtask

   task automatic compare();
      for (int p = 0; p < NP; p++) begin
         vectors++;
         if (resp[p] !== exp_r[p] || result[p] !== exp_d[p]) begin
            miscompares++;
            $display("FAIL %s port %0d: resp %0d result %h, expected resp %0d result %h",
                     exp_t[p], p, resp[p], result[p], exp_r[p], exp_d[p]);
         end
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic put(input int p, input logic [3:0] c, input logic [W-1:0] d);
      cmd[p]  = c;
      data[p] = d;
   endtask

   task automatic quiet();
      for (int p = 0; p < NP; p++) put(p, 4'd0, '0);
   endtask

   task automatic single(input int p, input logic [3:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b);
      put(p, c, a); step();
      put(p, 4'd0, b); step();
      put(p, 4'd0, '0);
      repeat (4) step();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      quiet();
      rst = 1'b1;
      repeat (3) step();            // R1
      rst = 1'b0;
      step();

      single(0, 4'd1, 32'd5, 32'd7);                     // R2
      single(1, 4'd1, 32'hFFFF_FFFF, 32'd1);             // R4
      single(2, 4'd2, 32'd10, 32'd3);                    // R3
      single(3, 4'd2, 32'd3, 32'd10);                    // R3 borrow
      single(0, 4'd5, 32'd1, 32'd31);                    // R5
      single(1, 4'd6, 32'h8000_0000, 32'd31);            // R5
      single(2, 4'd5, 32'hA5A5_A5A5, 32'd0);             // R5
      single(3, 4'd6, 32'hF0F0_F0F0, 32'd4);             // R5
      single(0, 4'd5, 32'd1, 32'd32);                    // R6
      single(1, 4'd6, 32'd1, 32'hFFFF_FFFF);             // R6

      // R7: invalid codes on all ports at once
      put(0, 4'd3, 32'd1); put(1, 4'd4, 32'd2); put(2, 4'd7, 32'd3); put(3, 4'd15, 32'd4);
      step(); quiet(); put(0, 4'd0, 32'd9); step(); quiet();
      repeat (4) step();

      // R8: no-op with busy data lines
      idle_tag = "R8";
      for (int i = 0; i < 20; i++) begin
         for (int p = 0; p < NP; p++) put(p, 4'd0, $urandom());
         step();
      end
      quiet();
      idle_tag = "R11";
      step();

      // R9: four adds in the same cycle, then two adds and two shifts
      for (int p = 0; p < NP; p++) put(p, 4'd1, 32'(p + 100));
      step();
      for (int p = 0; p < NP; p++) put(p, 4'd0, 32'(p * 3));
      step();
      quiet();
      repeat (8) step();
      put(0, 4'd5, 32'h3); put(1, 4'd2, 32'd50); put(2, 4'd6, 32'hFF00); put(3, 4'd1, 32'd8);
      step();
      put(0, 4'd0, 32'd4); put(1, 4'd0, 32'd20); put(2, 4'd0, 32'd8); put(3, 4'd0, 32'd8);
      step();
      quiet();
      repeat (8) step();

      // R10: commands on a queued port, colliding with its turn at the head
      for (int p = 0; p < NP; p++) put(p, 4'd1, 32'(p + 1));
      step();
      for (int p = 0; p < NP; p++) put(p, 4'd0, 32'd10);
      step();
      quiet();
      put(3, 4'd2, 32'd0); step();
      put(3, 4'd1, 32'd0); step();
      put(1, 4'd6, 32'd0); step();
      quiet();
      repeat (10) step();

      // mixed random traffic, violations included
      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < NP; p++) begin
            int r = $urandom_range(0, 13);
            logic [3:0] c;
            case (r)
               6: c = 4'd1;  7: c = 4'd2;  8: c = 4'd5;  9: c = 4'd6;
               10: c = 4'd1; 11: c = 4'd5; 12: c = 4'd3; 13: c = 4'd12;
               default: c = 4'd0;
            endcase
            put(p, c, ($urandom_range(0, 2) == 0) ? 32'($urandom_range(0, 40)) : $urandom());
         end
         step();
      end
      quiet();
      repeat (12) step();

      // R1: reset in the middle of traffic
      for (int p = 0; p < NP; p++) put(p, 4'd1, 32'd1);
      step();
      rst = 1'b1;
      quiet();
      repeat (2) step();
      rst = 1'b0;
      repeat (6) step();

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule